// File: doc/BRIEF.md
# Asynchronous static RAM access sequencer

This block sits between a clocked system and an asynchronous static RAM. It takes one single-word read or write request at a time and turns it into the control sequence the RAM needs. On the RAM side it drives the address, an active-low chip select, an active-high chip enable, an active-low output enable, an active-low write enable and the write data. Because the data bus is bidirectional, the block drives it through a pad: data out, a drive enable and data in. Every timing window is a parameter counted in clock cycles, and each has a floor of one cycle.

A write presents the address and data first and waits out a setup window. It then pulls write enable low for the pulse width and raises it again. After that it holds address and data for a hold window, and finally deselects the RAM for a recovery window. A read selects the RAM with output enable low and waits the access window, which is stretched up to the minimum cycle time when that is longer. It samples the bus and returns the word with a one-cycle valid pulse. A read request accepted in the last cycle of a read keeps the chip selected and only moves the address, so the access wait starts again. After any read, output enable stays high for the disable window before the block lets go of the bus or drives it.

Top module: `sram_ctrl`

## Requirements
- R1: `sram_oe_no` is low only while `sram_cs_no` is low, `sram_ce_o` is high and `sram_we_no` is high.
- R2: `sram_we_no` is low only while `sram_cs_no` is low, `sram_ce_o` is high and `sram_oe_no` is high, and each write holds it low for exactly T_PULSE cycles.
- R3: Between two write pulses, `sram_we_no` stays high for at least T_HOLD+T_RECOV cycles, and the RAM is deselected (`sram_cs_no` high, `sram_ce_o` low) for at least T_RECOV of them.
- R4: The write address and data are on the bus, with `sram_dq_oe_o` high, for at least T_SETUP cycles before `sram_we_no` falls. Both stay unchanged for the whole pulse.
- R5: In the first cycle after `sram_we_no` rises, address and data are unchanged and still driven. They stay so for T_HOLD cycles.
- R6: A read accepted at clock edge A returns the RAM word on `rsp_rdata_o` with `rsp_valid_o` high for one cycle, starting RD_LEN = max(T_ACCESS, T_CYCLE) edges after A. The word is sampled only after at least T_ACCESS cycles with a stable address and read controls active.
- R7: A read accepted while another read is in its final cycle keeps `sram_cs_no` low and `sram_ce_o` high. Only the address changes, and the access wait restarts.
- R8: `sram_dq_oe_o` is high only during write setup, pulse and hold, never with `sram_oe_no` low. It rises only after `sram_oe_no` has been high for at least T_DIS cycles.
- R9: After reset and when idle, `sram_cs_no`=1, `sram_ce_o`=0, `sram_oe_no`=1, `sram_we_no`=1 and `sram_dq_oe_o`=0.
- R10: `req_ready_o` is high only when idle or in the final cycle of a read. A request is taken on an edge where `req_valid_i` and `req_ready_o` are both high, and `req_we_i`=1 marks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle read-data strobe |
| rsp_rdata_o | output | DW | Read data |
| sram_addr_o | output | AW | RAM address |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_ce_o | output | 1 | Chip enable, active high |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_dq_o | output | DW | Data toward the RAM |
| sram_dq_oe_o | output | 1 | Pad drive enable for sram_dq_o |
| sram_dq_i | input | DW | Data from the RAM |

## Verification
A sequencer state that is wrong or slips by one cycle shows up on the RAM pins straight away. The bench sees it in the same cycle as a write pulse of the wrong length, a setup or hold window that is too short, or the bus being driven while output enable is low. If the access wait ends too soon, the bench's RAM model still returns its poison word. That word reaches `rsp_rdata_o` RD_LEN cycles after the request, and a response that comes too early or too late is flagged by its cycle stamp. A lost or extra accept shows as a missing or unexpected read response, which the bench notices at the latest when it drains its expectations at the end.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WPUL, ST_WHLD, ST_WREC, ST_RACC, ST_RDIS
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic ce;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } ctl_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic ctl_t ctl_decode(input state_e s);
    ctl_t c;
    c = '{cs_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_WSET: c = '{cs_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
      ST_WPUL: c = '{cs_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      ST_WHLD: c = '{cs_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
      ST_RACC: c = '{cs_n: 1'b0, ce: 1'b1, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_HOLD   = 1,
  parameter int T_RECOV  = 2,
  parameter int T_ACCESS = 3,
  parameter int T_CYCLE  = 4,
  parameter int T_DIS    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic ready_o,
  output logic accept_o,
  output logic rd_done_o,
  output ctl_t ctl_o
);
  localparam int P_SET  = max2(T_SETUP, 1);
  localparam int P_PUL  = max2(T_PULSE, 1);
  localparam int P_HLD  = max2(T_HOLD, 1);
  localparam int P_REC  = max2(T_RECOV, 1);
  localparam int P_DIS  = max2(T_DIS, 1);
  localparam int RD_LEN = max2(max2(T_ACCESS, T_CYCLE), 1);
  localparam int MAXT   = max2(max2(max2(P_SET, P_PUL), max2(P_HLD, P_REC)), max2(P_DIS, RD_LEN));
  localparam int CW     = $clog2(MAXT + 1);
  localparam logic [CW-1:0] L_SET = CW'(P_SET - 1);
  localparam logic [CW-1:0] L_PUL = CW'(P_PUL - 1);
  localparam logic [CW-1:0] L_HLD = CW'(P_HLD - 1);
  localparam logic [CW-1:0] L_REC = CW'(P_REC - 1);
  localparam logic [CW-1:0] L_DIS = CW'(P_DIS - 1);
  localparam logic [CW-1:0] L_RD  = CW'(RD_LEN - 1);

  state_e        state_q, state_d;
  logic          pend_q, pend_d;
  logic          load;
  logic [CW-1:0] load_val;
  logic          tmr_done;

  sram_ctrl_timer #(.CW(CW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (tmr_done)
  );

  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_RACC && tmr_done);
  assign accept_o  = ready_o && req_valid_i;
  assign rd_done_o = (state_q == ST_RACC) && tmr_done;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE: if (accept_o) begin
        load = 1'b1;
        if (req_we_i) begin state_d = ST_WSET; load_val = L_SET; end
        else          begin state_d = ST_RACC; load_val = L_RD;  end
      end
      ST_WSET: if (tmr_done) begin state_d = ST_WPUL; load = 1'b1; load_val = L_PUL; end
      ST_WPUL: if (tmr_done) begin state_d = ST_WHLD; load = 1'b1; load_val = L_HLD; end
      ST_WHLD: if (tmr_done) begin state_d = ST_WREC; load = 1'b1; load_val = L_REC; end
      ST_WREC: if (tmr_done) state_d = ST_IDLE;
      ST_RACC: if (tmr_done) begin
        load = 1'b1;
        if (accept_o && !req_we_i) begin
          load_val = L_RD;  // address moves, access wait restarts
        end else begin
          state_d  = ST_RDIS;
          load_val = L_DIS;
          pend_d   = accept_o;
        end
      end
      ST_RDIS: if (tmr_done) begin
        if (pend_q) begin
          state_d  = ST_WSET;
          pend_d   = 1'b0;
          load     = 1'b1;
          load_val = L_SET;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      ctl_o   <= ctl_decode(ST_IDLE);
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      ctl_o   <= ctl_decode(state_d);
    end
  end
endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          rd_done_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rsp_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o      <= '0;
      wdata_o     <= '0;
      rdata_o     <= '0;
      rsp_valid_o <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
      end
      if (rd_done_i) rdata_o <= dq_i;
      rsp_valid_o <= rd_done_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_HOLD   = 1,
  parameter int T_RECOV  = 2,
  parameter int T_ACCESS = 3,
  parameter int T_CYCLE  = 4,
  parameter int T_DIS    = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_cs_no,
  output logic          sram_ce_o,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  logic accept;
  logic rd_done;
  ctl_t ctl;

  sram_ctrl_fsm #(
    .T_SETUP (T_SETUP),
    .T_PULSE (T_PULSE),
    .T_HOLD  (T_HOLD),
    .T_RECOV (T_RECOV),
    .T_ACCESS(T_ACCESS),
    .T_CYCLE (T_CYCLE),
    .T_DIS   (T_DIS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .rd_done_o   (rd_done),
    .ctl_o       (ctl)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rd_done_i   (rd_done),
    .dq_i        (sram_dq_i),
    .addr_o      (sram_addr_o),
    .wdata_o     (sram_dq_o),
    .rdata_o     (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o)
  );

  assign sram_cs_no   = ctl.cs_n;
  assign sram_ce_o    = ctl.ce;
  assign sram_oe_no   = ctl.oe_n;
  assign sram_we_no   = ctl.we_n;
  assign sram_dq_oe_o = ctl.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1,
  parameter int T_RECOV = 2,
  parameter int T_DIS   = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_cs_no,
  input logic          sram_ce_o,
  input logic          sram_oe_no,
  input logic          sram_we_no,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe_o
);
  localparam int P_PUL = max2(T_PULSE, 1);
  localparam int P_HLD = max2(T_HOLD, 1);
  localparam int P_REC = max2(T_RECOV, 1);
  localparam int P_DIS = max2(T_DIS, 1);

  logic [15:0] wlow_q, whigh_q, oeh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wlow_q  <= '0;
      whigh_q <= '1;
      oeh_q   <= '1;
    end else begin
      wlow_q  <= sram_we_no ? '0 : ((wlow_q == '1) ? wlow_q : wlow_q + 1'b1);
      whigh_q <= !sram_we_no ? '0 : ((whigh_q == '1) ? whigh_q : whigh_q + 1'b1);
      oeh_q   <= !sram_oe_no ? '0 : ((oeh_q == '1) ? oeh_q : oeh_q + 1'b1);
    end
  end

  AST_OE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (!sram_cs_no && sram_ce_o && sram_we_no)); // R1
  AST_WE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_cs_no && sram_ce_o && sram_oe_no)); // R2
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (int'(wlow_q) == P_PUL)); // R2
  AST_WE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> (int'(whigh_q) >= P_HLD + P_REC)); // R3
  AST_ADDR_STABLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> ($stable(sram_addr_o) && $stable(sram_dq_o) && sram_dq_oe_o)); // R4
  AST_SETUP_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $past(sram_dq_oe_o)); // R4
  AST_HOLD_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> ($stable(sram_addr_o) && $stable(sram_dq_o) && sram_dq_oe_o)); // R5
  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!sram_oe_no)); // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no); // R8
  AST_BUS_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (int'(oeh_q) >= P_DIS)); // R8
  AST_DESEL_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_cs_no |-> (!sram_ce_o && sram_oe_no && sram_we_no && !sram_dq_oe_o)); // R9
  AST_NO_READY_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_we_no && !sram_dq_oe_o)); // R10
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .AW(AW), .DW(DW), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_RECOV(T_RECOV), .T_DIS(T_DIS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_cs_no   (sram_cs_no),
  .sram_ce_o    (sram_ce_o),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;
  localparam int AW = 16, DW = 16;
  localparam int T_SETUP = 1, T_PULSE = 2, T_HOLD = 1, T_RECOV = 2;
  localparam int T_ACCESS = 3, T_CYCLE = 4, T_DIS = 1;
  localparam int RD_LEN = (T_ACCESS > T_CYCLE) ? T_ACCESS : T_CYCLE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] addr;
  logic cs_n, ce, oe_n, we_n, dq_oe;
  logic [DW-1:0] dq_o, dq_i;

  always #2.5 clk = ~clk;

  sram_ctrl #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
    .T_RECOV(T_RECOV), .T_ACCESS(T_ACCESS), .T_CYCLE(T_CYCLE), .T_DIS(T_DIS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sram_addr_o(addr),
    .sram_cs_no(cs_n), .sram_ce_o(ce), .sram_oe_no(oe_n), .sram_we_no(we_n),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // RAM model: read data valid only after T_ACCESS stable selected cycles
  logic [DW-1:0] mem [64];
  int age = 0;
  logic [AW-1:0] last_a = '0;
  wire rd_sel = !cs_n && ce && !oe_n && we_n;
  assign dq_i = (rd_sel && age >= T_ACCESS) ? mem[addr[5:0]] : 16'hBAD0;

  logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
  int wlen = 0, whi = 1000, desel = 1000, setup_cnt = 0, oeh = 1000, cs_hi_cnt = 0;
  bit had_write = 0;
  logic [AW-1:0] w_a;
  logic [DW-1:0] w_d;

  always @(negedge clk) if (rst_n) begin
    if (!oe_n && prev_oe_n)
      check(!cs_n && ce && we_n, "R1", "read controls at oe fall", {cs_n, ce, we_n}, 3'b011);
    if (dq_oe && !prev_dq_oe)
      check(oeh >= T_DIS, "R8", "oe high cycles before drive", oeh, T_DIS);
    if (!we_n && prev_we_n) begin
      check(!cs_n && ce && oe_n, "R2", "write controls at we fall", {cs_n, ce, oe_n}, 3'b011);
      check(setup_cnt >= T_SETUP, "R4", "setup cycles", setup_cnt, T_SETUP);
      if (had_write) begin
        check(whi >= T_HOLD + T_RECOV, "R3", "we high gap", whi, T_HOLD + T_RECOV);
        check(desel >= T_RECOV, "R3", "deselect cycles", desel, T_RECOV);
      end
      w_a = addr; w_d = dq_o;
    end
    if (!we_n && !(addr == w_a && dq_o == w_d && dq_oe))
      check(0, "R4", "addr/data moved in pulse", addr, w_a);
    if (we_n && !prev_we_n) begin
      check(wlen == T_PULSE, "R2", "pulse length", wlen, T_PULSE);
      check(addr == w_a && dq_o == w_d && dq_oe, "R5", "hold after we rise", dq_o, w_d);
      mem[w_a[5:0]] = w_d;
      had_write = 1;
      desel = 0;
    end
    // counter updates after checks
    if (rd_sel) age = (addr == last_a && age > 0) ? age + 1 : 1; else age = 0;
    last_a = addr;
    wlen = !we_n ? wlen + 1 : 0;
    whi = we_n ? whi + 1 : 0;
    if (cs_n && !ce) desel++;
    if (cs_n) cs_hi_cnt++;
    setup_cnt = (dq_oe && we_n && !prev_we_n) ? 0 : ((dq_oe && we_n) ? setup_cnt + 1 : 0);
    oeh = oe_n ? oeh + 1 : 0;
    prev_we_n = we_n; prev_oe_n = oe_n; prev_dq_oe = dq_oe;
  end

  // scoreboard
  logic [DW-1:0] shadow [64];
  logic [DW-1:0] exp_d[$];
  int exp_c[$];

  task automatic do_req(input logic we, input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = {10'b0, a}; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (!we) begin
      exp_d.push_back(shadow[a]);
      exp_c.push_back(cyc + 1 + RD_LEN);
    end else shadow[a] = d;
    @(posedge clk);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_d.size() == 0) check(0, "R6", "unexpected response", rsp_rdata, 0);
    else begin
      logic [DW-1:0] ed;
      int ec;
      ed = exp_d.pop_front();
      ec = exp_c.pop_front();
      check(rsp_rdata == ed, "R6", "read data", rsp_rdata, ed);
      check(cyc == ec, "R6", "response cycle", cyc, ec);
    end
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    check({cs_n, ce, oe_n, we_n, dq_oe} == 5'b10110, "R9", "reset pins",
          {cs_n, ce, oe_n, we_n, dq_oe}, 5'b10110);
    check(req_ready == 1'b1, "R10", "ready in reset idle", req_ready, 1);
    rst_n = 1'b1;

    // back-to-back writes
    do_req(1, 6'd3, 16'hA5A5);
    do_req(1, 6'd4, 16'h5A5A);
    do_req(1, 6'd63, 16'hFFFF);
    do_req(1, 6'd0, 16'h0001);
    @(negedge clk);
    check(req_ready == 1'b0, "R10", "ready low during write", req_ready, 0);
    req_valid = 1'b0;
    go_idle(12);
    check({cs_n, ce, oe_n, we_n, dq_oe} == 5'b10110, "R9", "idle pins",
          {cs_n, ce, oe_n, we_n, dq_oe}, 5'b10110);

    // isolated reads
    do_req(0, 6'd3, '0);  go_idle(8);
    do_req(0, 6'd63, '0); go_idle(8);
    do_req(0, 6'd9, '0);  go_idle(8);

    // back-to-back reads: chip stays selected (R7)
    do_req(0, 6'd4, '0);
    s0 = cs_hi_cnt;
    do_req(0, 6'd0, '0);
    do_req(0, 6'd3, '0);
    do_req(0, 6'd63, '0);
    check(cs_hi_cnt == s0, "R7", "cs high cycles inside read burst", cs_hi_cnt, s0);
    // read then write taken at read end: turnaround (R8), then read back
    do_req(0, 6'd4, '0);
    do_req(1, 6'd4, 16'h1234);
    do_req(0, 6'd4, '0);
    go_idle(10);
    do_req(1, 6'd20, 16'hC0DE);
    do_req(0, 6'd20, '0);
    go_idle(12);
    check({cs_n, ce, oe_n, we_n, dq_oe} == 5'b10110, "R9", "final idle pins",
          {cs_n, ce, oe_n, we_n, dq_oe}, 5'b10110);
    check(exp_d.size() == 0, "R6", "outstanding reads", exp_d.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule